// File: doc/BRIEF.md
# HI/LO Multiply-Divide Unit

This unit is the multiply and divide engine of a 64-bit integer core. It owns two 64-bit result registers, HI and LO. It takes one operation per cycle from the issue stage: a 4-bit operation code, two 64-bit source operands and a 5-bit destination register index. Register-producing operations return a 64-bit value and a one-cycle write enable for the general register file.

Every arithmetic operation uses only the low 32 bits of its operands. Each 32-bit result is sign-extended from bit 31 before it reaches HI, LO or the register file. Multiplies finish in the cycle they are accepted. Divides run a restoring shift-subtract loop for 32 cycles and hold `busy` high for that whole time. A read of HI or LO that arrives during a divide is parked. It is answered in the cycle the divide retires, using the new HI or LO value.

Operation codes: 1 signed multiply, 2 unsigned multiply, 3 multiply-to-register, 4 signed divide, 5 unsigned divide, 6 write HI, 7 write LO, 8 read HI, 9 read LO. Codes 0 and 10 to 15 do nothing.

Top module: `hilo_muldiv`

## Requirements
- R1: Code 1, accepted while idle, forms the signed 64-bit product P of the two low 32-bit operand halves. From the next cycle, LO holds P[31:0] sign-extended and HI holds P[63:32] sign-extended. The upper operand halves have no effect.
- R2: Code 2 does the same with both halves taken as unsigned. Each 32-bit half of the product is still sign-extended into HI and LO.
- R3: Code 3 raises `wr_en` for one cycle, in the cycle after it is accepted. `wr_idx` carries `dst_idx`, and `wr_data` carries the low 32 bits of the signed product, sign-extended. It does not set `busy`.
- R4: Code 4 divides the low halves as signed values, truncating toward zero. LO receives the quotient and HI the remainder, each sign-extended. A dividend of 0x80000000 divided by 0xFFFFFFFF gives LO = 0xFFFFFFFF80000000 and HI = 0.
- R5: Code 5 divides the low halves as unsigned values. The quotient and remainder are still sign-extended from bit 31 into LO and HI.
- R6: Codes 4 and 5 with a zero low divisor half still run the full divide time, then leave HI and LO unchanged.
- R7: Codes 6 and 7 copy all 64 bits of `src_a` into HI or LO respectively.
- R8: Codes 8 and 9 raise `wr_en` in the next cycle with the current HI or LO value and `wr_idx = dst_idx`. When `dst_idx` is 0, `wr_en` stays low.
- R9: Once a divide is accepted, `busy` is high for exactly 32 cycles, starting in the following cycle. The multiply codes never raise `busy`.
- R10: While `busy` is high, the first code 8 or 9 is held. It is answered with `wr_en` in the cycle `busy` falls, carrying the updated HI or LO. Every other operation presented while busy is ignored.
- R11: After reset, HI and LO read as 0, and `busy` and `wr_en` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op_code | input | 4 | Operation code (see the list above) |
| src_a | input | 64 | First operand (dividend, multiplicand, or value for HI/LO writes) |
| src_b | input | 64 | Second operand (divisor, multiplier) |
| dst_idx | input | 5 | Destination register index |
| busy | output | 1 | A divide is in progress |
| wr_en | output | 1 | Register file write strobe |
| wr_idx | output | 5 | Register file write index |
| wr_data | output | 64 | Register file write data |

## Verification
The latency of each result is set by the operation:
- Multiplies and HI/LO writes update state one edge after acceptance, so a read issued in the next cycle already sees them.
- Code 3 and idle reads show `wr_en` one cycle after acceptance.
- A divide leaves `busy` high for 32 cycles. HI, LO and any parked read appear in the cycle `busy` drops.

The bench model advances its state on the same rising edges as the design. It compares `busy`, `wr_en`, `wr_idx` and `wr_data` at every falling edge, when both sides have settled. The directed checks sample in the cycle after the issuing edge, or in the first cycle with `busy` low.

// File: rtl/hilo_muldiv.sv
module hilo_muldiv #(
  parameter int XLEN  = 64,
  parameter int HALF  = 32,
  parameter int RIDX  = 5,
  parameter int OPW   = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            op_valid,
  input  logic [OPW-1:0]  op_code,
  input  logic [XLEN-1:0] src_a,
  input  logic [XLEN-1:0] src_b,
  input  logic [RIDX-1:0] dst_idx,
  output logic            busy,
  output logic            wr_en,
  output logic [RIDX-1:0] wr_idx,
  output logic [XLEN-1:0] wr_data
);
  localparam int CW = $clog2(HALF + 1);
  localparam logic [OPW-1:0] OP_MULS  = OPW'(1);
  localparam logic [OPW-1:0] OP_MULU  = OPW'(2);
  localparam logic [OPW-1:0] OP_MULLO = OPW'(3);
  localparam logic [OPW-1:0] OP_DIVS  = OPW'(4);
  localparam logic [OPW-1:0] OP_DIVU  = OPW'(5);
  localparam logic [OPW-1:0] OP_SETHI = OPW'(6);
  localparam logic [OPW-1:0] OP_SETLO = OPW'(7);
  localparam logic [OPW-1:0] OP_GETHI = OPW'(8);
  localparam logic [OPW-1:0] OP_GETLO = OPW'(9);

  function automatic logic [XLEN-1:0] sx(input logic [HALF-1:0] v);
    return {{(XLEN-HALF){v[HALF-1]}}, v};
  endfunction

  logic [XLEN-1:0] hi_q, lo_q;
  logic [CW-1:0]   cnt_q;
  logic [HALF-1:0] rem_q, quo_q, dvs_q;
  logic            negq_q, negr_q, dz_q;
  logic            pend_q, pend_hi_q;
  logic [RIDX-1:0] pend_idx_q;

  wire [HALF-1:0] a_lo = src_a[HALF-1:0];
  wire [HALF-1:0] b_lo = src_b[HALF-1:0];
  logic unused_b_upper;
  assign unused_b_upper = ^src_b[XLEN-1:HALF];

  assign busy = (cnt_q != '0);

  wire [XLEN-1:0] prod_s = sx(a_lo) * sx(b_lo);
  wire [XLEN-1:0] prod_u = {{(XLEN-HALF){1'b0}}, a_lo} * {{(XLEN-HALF){1'b0}}, b_lo};

  wire            sgn    = (op_code == OP_DIVS);
  wire            a_neg  = sgn & a_lo[HALF-1];
  wire            b_neg  = sgn & b_lo[HALF-1];
  wire [HALF-1:0] a_mag  = a_neg ? -a_lo : a_lo;
  wire [HALF-1:0] b_mag  = b_neg ? -b_lo : b_lo;

  wire [HALF:0]   shf    = {rem_q, quo_q[HALF-1]};
  wire [HALF:0]   dif    = shf - {1'b0, dvs_q};
  wire            take   = ~dif[HALF];
  wire [HALF-1:0] nrem   = take ? dif[HALF-1:0] : shf[HALF-1:0];
  wire [HALF-1:0] nquo   = {quo_q[HALF-2:0], take};
  wire [HALF-1:0] fq     = negq_q ? -nquo : nquo;
  wire [HALF-1:0] fr     = negr_q ? -nrem : nrem;
  wire [XLEN-1:0] fin_hi = dz_q ? hi_q : sx(fr);
  wire [XLEN-1:0] fin_lo = dz_q ? lo_q : sx(fq);
  wire            last   = (cnt_q == CW'(1));

  wire            is_get  = (op_code == OP_GETHI) || (op_code == OP_GETLO);
  wire            cap_get = op_valid && is_get && !pend_q;
  wire            eff_pv  = pend_q || cap_get;
  wire            eff_hi  = pend_q ? pend_hi_q : (op_code == OP_GETHI);
  wire [RIDX-1:0] eff_idx = pend_q ? pend_idx_q : dst_idx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q <= '0; lo_q <= '0; cnt_q <= '0;
      rem_q <= '0; quo_q <= '0; dvs_q <= '0;
      negq_q <= 1'b0; negr_q <= 1'b0; dz_q <= 1'b0;
      pend_q <= 1'b0; pend_hi_q <= 1'b0; pend_idx_q <= '0;
      wr_en <= 1'b0; wr_idx <= '0; wr_data <= '0;
    end else begin
      wr_en <= 1'b0;
      if (busy) begin
        rem_q <= nrem;
        quo_q <= nquo;
        cnt_q <= cnt_q - CW'(1);
        if (cap_get) begin
          pend_q     <= 1'b1;
          pend_hi_q  <= (op_code == OP_GETHI);
          pend_idx_q <= dst_idx;
        end
        if (last) begin
          pend_q  <= 1'b0;
          hi_q    <= fin_hi;
          lo_q    <= fin_lo;
          wr_en   <= eff_pv && (eff_idx != '0);
          wr_idx  <= eff_idx;
          wr_data <= eff_hi ? fin_hi : fin_lo;
        end
      end else if (op_valid) begin
        case (op_code)
          OP_MULS: begin
            hi_q <= sx(prod_s[XLEN-1:HALF]);
            lo_q <= sx(prod_s[HALF-1:0]);
          end
          OP_MULU: begin
            hi_q <= sx(prod_u[XLEN-1:HALF]);
            lo_q <= sx(prod_u[HALF-1:0]);
          end
          OP_MULLO: begin
            wr_en   <= 1'b1;
            wr_idx  <= dst_idx;
            wr_data <= sx(prod_s[HALF-1:0]);
          end
          OP_DIVS, OP_DIVU: begin
            cnt_q  <= CW'(HALF);
            rem_q  <= '0;
            quo_q  <= a_mag;
            dvs_q  <= b_mag;
            negq_q <= a_neg ^ b_neg;
            negr_q <= a_neg;
            dz_q   <= (b_lo == '0);
          end
          OP_SETHI: hi_q <= src_a;
          OP_SETLO: lo_q <= src_a;
          OP_GETHI, OP_GETLO: begin
            wr_en   <= (dst_idx != '0);
            wr_idx  <= dst_idx;
            wr_data <= (op_code == OP_GETHI) ? hi_q : lo_q;
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/hilo_muldiv_chk.sv
module hilo_muldiv_chk #(
  parameter int STEPS = 32
) (
  input logic        clk,
  input logic        rst_n,
  input logic        op_valid,
  input logic [3:0]  op_code,
  input logic [4:0]  dst_idx,
  input logic        busy,
  input logic        wr_en,
  input logic [32:0] wr_top
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) run_q <= '0;
    else        run_q <= busy ? run_q + 8'd1 : 8'd0;
  end

  // R9
  div_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && (op_code == 4'd4 || op_code == 4'd5)) |=> busy);

  // R9
  mul_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && (op_code == 4'd1 || op_code == 4'd2 || op_code == 4'd3)) |=> !busy);

  // R9
  busy_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (run_q < 8'(STEPS)));

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (run_q == 8'(STEPS)));

  // R3
  mul_sext_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && op_code == 4'd3) |=> (wr_en && (wr_top[32:1] == {32{wr_top[0]}})));

  // R8
  zero_dst_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && (op_code == 4'd8 || op_code == 4'd9) && dst_idx == 5'd0) |=> !wr_en);

  // R10
  div_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !busy && (op_code == 4'd4 || op_code == 4'd5)) |=> !wr_en);
endmodule

bind hilo_muldiv hilo_muldiv_chk u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
  .dst_idx(dst_idx), .busy(busy), .wr_en(wr_en), .wr_top(wr_data[63:31])
);

// File: tb/hilo_muldiv_tb.sv
module hilo_muldiv_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        op_valid = 1'b0;
  logic [3:0]  op_code = '0;
  logic [63:0] src_a = '0, src_b = '0;
  logic [4:0]  dst_idx = '0;
  logic        busy, wr_en;
  logic [4:0]  wr_idx;
  logic [63:0] wr_data;

  always #10 clk = ~clk;

  hilo_muldiv u_dut (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .src_a(src_a), .src_b(src_b), .dst_idx(dst_idx),
    .busy(busy), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] sx(input logic [31:0] v);
    return {{32{v[31]}}, v};
  endfunction

  // behavioural reference model
  int          m_left = 0;
  logic [63:0] m_hi = '0, m_lo = '0, m_nhi = '0, m_nlo = '0;
  bit          m_dz = 0, m_pv = 0, m_phi = 0, m_wr = 0;
  logic [4:0]  m_pidx = '0, m_widx = '0;
  logic [63:0] m_wdata = '0;
  string       m_tag = "R11";

  task automatic model_op();
    longint x, y, q, r;
    logic [63:0] p, qv, rv;
    case (op_code)
      4'd1: begin
        x = $signed(src_a[31:0]); y = $signed(src_b[31:0]); p = x * y;
        m_lo = sx(p[31:0]); m_hi = sx(p[63:32]); m_tag = "R1";
      end
      4'd2: begin
        p = {32'b0, src_a[31:0]} * {32'b0, src_b[31:0]};
        m_lo = sx(p[31:0]); m_hi = sx(p[63:32]); m_tag = "R2";
      end
      4'd3: begin
        x = $signed(src_a[31:0]); y = $signed(src_b[31:0]); p = x * y;
        m_wr = 1; m_widx = dst_idx; m_wdata = sx(p[31:0]); m_tag = "R3";
      end
      4'd4, 4'd5: begin
        if (op_code == 4'd4) begin
          x = $signed(src_a[31:0]); y = $signed(src_b[31:0]); m_tag = "R4";
        end else begin
          x = longint'({32'b0, src_a[31:0]}); y = longint'({32'b0, src_b[31:0]}); m_tag = "R5";
        end
        m_dz = (y == 0);
        if (!m_dz) begin
          q = x / y; r = x % y; qv = q; rv = r;
          m_nlo = sx(qv[31:0]); m_nhi = sx(rv[31:0]);
        end else m_tag = "R6";
        m_left = 32;
      end
      4'd6: begin m_hi = src_a; m_tag = "R7"; end
      4'd7: begin m_lo = src_a; m_tag = "R7"; end
      4'd8, 4'd9: begin
        m_tag = "R8";
        if (dst_idx != 0) begin
          m_wr = 1; m_widx = dst_idx; m_wdata = (op_code == 4'd8) ? m_hi : m_lo;
        end
      end
      default: ;
    endcase
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_left = 0; m_hi = '0; m_lo = '0; m_pv = 0; m_wr = 0;
    end else begin
      m_wr = 0;
      if (m_left > 0) begin
        if (op_valid && (op_code == 4'd8 || op_code == 4'd9) && !m_pv) begin
          m_pv = 1; m_phi = (op_code == 4'd8); m_pidx = dst_idx;
        end
        m_left--;
        if (m_left == 0) begin
          if (!m_dz) begin m_hi = m_nhi; m_lo = m_nlo; end
          if (m_pv && m_pidx != 0) begin
            m_wr = 1; m_widx = m_pidx; m_wdata = m_phi ? m_hi : m_lo;
          end
          m_tag = "R10";
          m_pv = 0;
        end
      end else if (op_valid) model_op();
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(busy === (m_left > 0), "R9 busy vs model", 64'(busy), 64'(m_left > 0));
      chk(wr_en === m_wr, {m_tag, " wr_en vs model"}, 64'(wr_en), 64'(m_wr));
      if (m_wr) begin
        chk(wr_idx === m_widx, {m_tag, " wr_idx vs model"}, 64'(wr_idx), 64'(m_widx));
        chk(wr_data === m_wdata, {m_tag, " wr_data vs model"}, wr_data, m_wdata);
      end
    end
  end

  task automatic issue(input logic [3:0] o, input logic [63:0] a, input logic [63:0] b, input logic [4:0] d);
    @(negedge clk);
    op_valid = 1; op_code = o; src_a = a; src_b = b; dst_idx = d;
    @(negedge clk);
    op_valid = 0;
  endtask

  task automatic wait_idle();
    while (busy) @(negedge clk);
  endtask

  task automatic read_chk(input logic [3:0] o, input logic [4:0] d, input logic [63:0] exp, input string req);
    issue(o, '0, '0, d);
    chk(wr_en === 1'b1, req, 64'(wr_en), 64'd1);
    chk(wr_idx === d, req, 64'(wr_idx), 64'(d));
    chk(wr_data === exp, req, wr_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=%h expected=%h", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(busy === 1'b0, "R11 busy in reset", 64'(busy), 64'd0);
    chk(wr_en === 1'b0, "R11 wr_en in reset", 64'(wr_en), 64'd0);
    rst_n = 1;
    read_chk(4'd8, 5'd3, 64'd0, "R11 HI after reset");
    read_chk(4'd9, 5'd4, 64'd0, "R11 LO after reset");

    // R1 signed multiply, upper operand halves ignored
    issue(4'd1, 64'hFFFF_FFFF_FFFF_FFFD, 64'h1234_5678_0000_0007, 5'd0);
    read_chk(4'd9, 5'd1, 64'hFFFF_FFFF_FFFF_FFEB, "R1 LO of -3*7");
    read_chk(4'd8, 5'd2, 64'hFFFF_FFFF_FFFF_FFFF, "R1 HI of -3*7");
    issue(4'd1, 64'hAAAA_AAAA_7FFF_FFFF, 64'h5555_5555_7FFF_FFFF, 5'd0);
    read_chk(4'd9, 5'd1, 64'h0000_0000_0000_0001, "R1 LO of max*max");
    read_chk(4'd8, 5'd2, 64'h0000_0000_3FFF_FFFF, "R1 HI of max*max");

    // R2 unsigned multiply
    issue(4'd2, 64'h0000_0000_FFFF_FFFF, 64'hFFFF_0000_FFFF_FFFF, 5'd0);
    read_chk(4'd9, 5'd5, 64'h0000_0000_0000_0001, "R2 LO unsigned");
    read_chk(4'd8, 5'd6, 64'hFFFF_FFFF_FFFF_FFFE, "R2 HI unsigned sext");

    // R3 multiply to register
    issue(4'd3, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000, 5'd7);
    chk(wr_en === 1'b1 && wr_idx === 5'd7, "R3 write strobe", 64'(wr_idx), 64'd7);
    chk(wr_data === 64'hFFFF_FFFF_8000_0000, "R3 sext product", wr_data, 64'hFFFF_FFFF_8000_0000);
    chk(busy === 1'b0, "R3 no busy", 64'(busy), 64'd0);

    // R4 signed divide
    issue(4'd4, 64'hFFFF_FFFF_FFFF_FFF9, 64'd2, 5'd0);
    wait_idle();
    read_chk(4'd9, 5'd1, 64'hFFFF_FFFF_FFFF_FFFD, "R4 quotient -7/2");
    read_chk(4'd8, 5'd1, 64'hFFFF_FFFF_FFFF_FFFF, "R4 remainder -7/2");
    issue(4'd4, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF, 5'd0);
    wait_idle();
    read_chk(4'd9, 5'd2, 64'hFFFF_FFFF_8000_0000, "R4 min/-1 quotient");
    read_chk(4'd8, 5'd2, 64'd0, "R4 min/-1 remainder");

    // R5 unsigned divide
    issue(4'd5, 64'h0000_0000_FFFF_FFFF, 64'd1, 5'd0);
    wait_idle();
    read_chk(4'd9, 5'd3, 64'hFFFF_FFFF_FFFF_FFFF, "R5 quotient sext");
    read_chk(4'd8, 5'd3, 64'd0, "R5 remainder");

    // R7 full-width writes, R6 divide by zero keeps them
    issue(4'd6, 64'h1234_5678_9ABC_DEF0, '0, 5'd0);
    issue(4'd7, 64'h0FED_CBA9_8765_4321, '0, 5'd0);
    read_chk(4'd8, 5'd4, 64'h1234_5678_9ABC_DEF0, "R7 HI write");
    read_chk(4'd9, 5'd4, 64'h0FED_CBA9_8765_4321, "R7 LO write");
    issue(4'd5, 64'd99, 64'hFFFF_FFFF_0000_0000, 5'd0);
    wait_idle();
    read_chk(4'd8, 5'd5, 64'h1234_5678_9ABC_DEF0, "R6 unsigned zero HI");
    read_chk(4'd9, 5'd5, 64'h0FED_CBA9_8765_4321, "R6 unsigned zero LO");
    issue(4'd4, 64'hFFFF_FFFF_FFFF_FFF0, 64'd0, 5'd0);
    wait_idle();
    read_chk(4'd8, 5'd6, 64'h1234_5678_9ABC_DEF0, "R6 signed zero HI");
    read_chk(4'd9, 5'd6, 64'h0FED_CBA9_8765_4321, "R6 signed zero LO");

    // R8 zero destination
    issue(4'd8, '0, '0, 5'd0);
    chk(wr_en === 1'b0, "R8 dst 0 no write", 64'(wr_en), 64'd0);

    // R9 busy length
    issue(4'd5, 64'd1000, 64'd3, 5'd0);
    n = 0;
    while (busy) begin n++; @(negedge clk); end
    chk(n == 32, "R9 busy cycles", 64'(n), 64'd32);
    issue(4'd2, 64'd5, 64'd6, 5'd0);
    chk(busy === 1'b0, "R9 multiply not busy", 64'(busy), 64'd0);

    // R10 held read and ignored ops while busy
    issue(4'd5, 64'd100, 64'd7, 5'd0);
    issue(4'd9, '0, '0, 5'd9);
    issue(4'd6, 64'hDEAD, '0, 5'd0);
    issue(4'd8, '0, '0, 5'd11);
    wait_idle();
    chk(wr_en === 1'b1 && wr_idx === 5'd9, "R10 held read index", 64'(wr_idx), 64'd9);
    chk(wr_data === 64'd14, "R10 held read value", wr_data, 64'd14);
    @(negedge clk);
    chk(wr_en === 1'b0, "R10 second read dropped", 64'(wr_en), 64'd0);
    read_chk(4'd8, 5'd8, 64'd2, "R10 write while busy ignored");

    // random traffic, checked every cycle against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      op_valid = ($urandom_range(0, 1) == 1);
      op_code  = 4'($urandom_range(0, 11));
      src_a    = {$urandom, $urandom};
      src_b    = {$urandom, $urandom};
      dst_idx  = 5'($urandom_range(0, 31));
      case ($urandom_range(0, 9))
        0: src_b[31:0] = 32'd0;
        1: begin src_a[31:0] = 32'h8000_0000; src_b[31:0] = 32'hFFFF_FFFF; end
        2: src_b[31:0] = 32'($urandom_range(1, 9));
        default: ;
      endcase
    end
    @(negedge clk);
    op_valid = 0;
    repeat (40) @(negedge clk);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule